// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block sits on the controller side of a four-bank double-data-rate SDRAM. It accepts one access request at a time. Each request names a bank, a row, a column, a direction and an optional auto-precharge flag. The block turns each request into the legal command sequence on a registered command/address bus: PRECHARGE if a different row is open in that bank, then ACTIVE if the bank is closed, then READ or WRITE once the activate-to-column delay has passed. The request is accepted in the cycle the column command is chosen, and that command appears on the bus one clock later.

Each bank keeps its own open-row state and timers. Rows left open in one bank stay open while other banks are used. A per-bank tracker enforces the activate-to-column delay, the minimum row-active time before a precharge, and the precharge-to-activate delay. A column command with auto precharge may issue as soon as the activate-to-column delay is met. The tracker then closes the row by itself once both the burst and the row-active minimum have finished. A refresh-interval timer raises a refresh demand that outranks new accesses. The block closes every open bank, issues AUTO REFRESH, and then blocks activates for the refresh cycle time.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, the bus carries NOP and `req_ready` is low.
- R2: Every bus code {cs_n,ras_n,cas_n,we_n} is one of NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, AUTO REFRESH=0001.
- R3: A request to a closed bank first produces ACTIVE to that bank, with the row on `cmd_addr[ROW_W-1:0]`. ACTIVE never targets a bank that is already open.
- R4: A column command carries the request's bank and direction (WRITE when `req_write`=1). The column is on the low address bits, and `cmd_addr[10]` equals the auto-precharge flag.
- R5: At least T_RCD cycles separate an ACTIVE from any column command to the same bank.
- R6: A request that hits the open row of its bank issues its column command with no new ACTIVE.
- R7: A request that misses the open row issues PRECHARGE (with `cmd_addr[10]`=0) and then ACTIVE. PRECHARGE comes at least T_RAS cycles after that bank's ACTIVE, and the next ACTIVE comes at least T_RP cycles after the PRECHARGE.
- R8: Rows open in other banks stay open while a bank is used. Returning to such a row needs no ACTIVE.
- R9: `burst_sel` 2'b01 selects a burst of 2 (1 clock), 2'b10 a burst of 4 (2 clocks), 2'b11 a burst of 8 (4 clocks), and 2'b00 is treated as 2. Back-to-back column commands are spaced exactly by the burst clocks.
- R10: After a column command with auto precharge, the bank closes with no PRECHARGE on the bus. The next ACTIVE to it waits for both the row-active minimum plus T_RP after its ACTIVE, and the burst end plus T_RP.
- R11: An AUTO REFRESH is issued about every T_REFI cycles, only with every bank closed. No ACTIVE follows it within T_RFC cycles.
- R12: A pending refresh outranks new requests, so a continuous request stream cannot delay a refresh beyond the row-close latency.
- R13: `req_ready` is high only with `req_valid`. Every accepted request produces exactly one column command on the next cycle, and no column command appears without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands launch on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| burst_sel | input | 2 | Burst length select (see R9) |
| req_valid | input | 1 | A request is presented |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the row automatically after this burst |
| req_bank | input | 2 | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| req_ready | output | 1 | Request accepted this cycle |
| cmd_n | output | 4 | {cs_n, ras_n, cas_n, we_n} command code |
| cmd_ba | output | 2 | Bank address of the command |
| cmd_addr | output | ADDR_W | Row, column plus auto-precharge bit, or zero for PRECHARGE |

## Verification
The bench goes after row hits, row misses and returns to a row left open in another bank. A design that loses track of open rows shows up as extra ACTIVEs, or as an ACTIVE sent to an already open bank. It measures the exact gap between back-to-back column commands for each burst selection, so a wrong burst-length decode or an off-by-one in the spacing counter is caught. For auto precharge, it checks that no PRECHARGE appears on the bus and that the reopening ACTIVE respects both the row-active minimum and the burst end. A design that closes the row at once would activate too early. A stream of row misses held across a refresh point shows whether refresh can be starved, and the refresh-cycle window after each AUTO REFRESH is checked.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

    localparam int NUM_BANKS = 4;
    localparam int BA_W      = 2;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001
    } ddr_cmd_e;

    typedef struct packed {
        logic open;      // a row is held open
        logic ap_busy;   // auto precharge scheduled, not yet closed
        logic can_act;   // closed and precharge/refresh time served
        logic can_col;   // open and activate-to-column delay served
        logic can_pre;   // open and row-active minimum served
    } bank_flags_t;

    // Data-bus clocks occupied by one burst.
    function automatic logic [2:0] burst_clocks(input logic [1:0] sel);
        case (sel)
            2'b10:   return 3'd2;
            2'b11:   return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/ddr_refresh_timer.sv
module ddr_refresh_timer #(
    parameter int T_REFI = 780,
    parameter int W      = $clog2(T_REFI + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic done_i,
    output logic pend_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= W'(T_REFI - 1);
            pend_o <= 1'b0;
        end else begin
            if (done_i)
                pend_o <= 1'b0;
            if (cnt_q == '0) begin
                cnt_q  <= W'(T_REFI - 1);
                pend_o <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
    import ddr_seq_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int CNT_W = 4,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RAS = 7,
    parameter int T_RFC = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic             col_i,
    input  logic             col_ap_i,
    input  logic             ref_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [2:0]       burst_i,
    output bank_flags_t      flags_o,
    output logic [ROW_W-1:0] row_o
);
    logic             open_q, ap_q;
    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] rcd_q, ras_q, rp_q;
    logic [2:0]       apc_q;
    logic             ap_close;

    assign ap_close = ap_q && (apc_q == '0) && (ras_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            ap_q   <= 1'b0;
            row_q  <= '0;
            rcd_q  <= '0;
            ras_q  <= '0;
            rp_q   <= '0;
            apc_q  <= '0;
        end else begin
            if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
            if (ras_q != '0) ras_q <= ras_q - 1'b1;
            if (rp_q  != '0) rp_q  <= rp_q  - 1'b1;
            if (apc_q != '0) apc_q <= apc_q - 1'b1;
            if (act_i) begin
                open_q <= 1'b1;
                row_q  <= row_i;
                rcd_q  <= CNT_W'(T_RCD - 1);
                ras_q  <= CNT_W'(T_RAS - 1);
            end
            if (pre_i) begin
                open_q <= 1'b0;
                rp_q   <= CNT_W'(T_RP - 1);
            end
            if (col_i && col_ap_i) begin
                ap_q  <= 1'b1;
                apc_q <= burst_i - 3'd1;
            end
            if (ap_close) begin
                ap_q   <= 1'b0;
                open_q <= 1'b0;
                rp_q   <= CNT_W'(T_RP - 1);
            end
            if (ref_i)
                rp_q <= CNT_W'(T_RFC - 1);
        end
    end

    always_comb begin
        flags_o.open    = open_q;
        flags_o.ap_busy = ap_q;
        flags_o.can_act = !open_q && (rp_q == '0);
        flags_o.can_col = open_q && !ap_q && (rcd_q == '0);
        flags_o.can_pre = open_q && !ap_q && (ras_q == '0);
    end

    assign row_o = row_q;
endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
    import ddr_seq_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int ADDR_W = 13,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 7,
    parameter int T_RFC  = 9,
    parameter int T_REFI = 780
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        burst_sel,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_autopre,
    input  logic [1:0]        req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              req_ready,
    output logic [3:0]        cmd_n,
    output logic [1:0]        cmd_ba,
    output logic [ADDR_W-1:0] cmd_addr
);
    localparam int T_A   = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int T_B   = (T_RAS > T_RFC) ? T_RAS : T_RFC;
    localparam int TMAX  = (T_A > T_B) ? T_A : T_B;
    localparam int CNT_W = $clog2(TMAX + 1);

    bank_flags_t          flags     [NUM_BANKS];
    logic [ROW_W-1:0]     open_rows [NUM_BANKS];
    logic [NUM_BANKS-1:0] act_sel, pre_sel, col_sel, idle_vec;
    logic                 ref_pend, ref_go;
    logic [2:0]           blen_clk, gap_q;

    ddr_cmd_e             nxt_code, cmd_q;
    logic [BA_W-1:0]      nxt_ba, ba_q;
    logic [ADDR_W-1:0]    nxt_addr, addr_q, row_addr, col_addr;

    assign blen_clk = burst_clocks(burst_sel);

    ddr_refresh_timer #(.T_REFI(T_REFI)) u_refi (
        .clk    (clk),
        .rst    (rst),
        .done_i (ref_go),
        .pend_o (ref_pend)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ddr_bank_tracker #(
            .ROW_W(ROW_W), .CNT_W(CNT_W), .T_RCD(T_RCD),
            .T_RP(T_RP), .T_RAS(T_RAS), .T_RFC(T_RFC)
        ) u_trk (
            .clk      (clk),
            .rst      (rst),
            .act_i    (act_sel[b]),
            .pre_i    (pre_sel[b]),
            .col_i    (col_sel[b]),
            .col_ap_i (req_autopre),
            .ref_i    (ref_go),
            .row_i    (req_row),
            .burst_i  (blen_clk),
            .flags_o  (flags[b]),
            .row_o    (open_rows[b])
        );
        assign idle_vec[b] = flags[b].can_act;
    end

    always_comb begin
        row_addr = '0;
        row_addr[ROW_W-1:0] = req_row;
        col_addr = '0;
        col_addr[COL_W-1:0] = req_col;
        col_addr[10] = req_autopre;
    end

    // One command per cycle; refresh first, then the presented request.
    always_comb begin
        bank_flags_t     fl;
        logic            hit, any_pre;
        logic [BA_W-1:0] pick;
        nxt_code = CMD_NOP;
        nxt_ba   = '0;
        nxt_addr = '0;
        act_sel  = '0;
        pre_sel  = '0;
        col_sel  = '0;
        ref_go   = 1'b0;
        any_pre  = 1'b0;
        pick     = '0;
        fl       = flags[req_bank];
        hit      = fl.open && (open_rows[req_bank] == req_row);
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (flags[b].can_pre) begin
                any_pre = 1'b1;
                pick    = BA_W'(b);
            end
        end
        if (ref_pend) begin
            if (&idle_vec) begin
                nxt_code = CMD_REF;
                ref_go   = 1'b1;
            end else if (any_pre) begin
                nxt_code      = CMD_PRE;
                nxt_ba        = pick;
                pre_sel[pick] = 1'b1;
            end
        end else if (req_valid && !fl.ap_busy) begin
            nxt_ba = req_bank;
            if (hit) begin
                if (fl.can_col && gap_q == '0) begin
                    nxt_code          = req_write ? CMD_WR : CMD_RD;
                    nxt_addr          = col_addr;
                    col_sel[req_bank] = 1'b1;
                end
            end else if (fl.open) begin
                if (fl.can_pre) begin
                    nxt_code          = CMD_PRE;
                    pre_sel[req_bank] = 1'b1;
                end
            end else if (fl.can_act) begin
                nxt_code          = CMD_ACT;
                nxt_addr          = row_addr;
                act_sel[req_bank] = 1'b1;
            end
        end
    end

    assign req_ready = |col_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
            gap_q  <= '0;
        end else begin
            cmd_q  <= nxt_code;
            ba_q   <= nxt_ba;
            addr_q <= nxt_addr;
            if (|col_sel)
                gap_q <= blen_clk - 3'd1;
            else if (gap_q != '0)
                gap_q <= gap_q - 3'd1;
        end
    end

    assign cmd_n    = cmd_q;
    assign cmd_ba   = ba_q;
    assign cmd_addr = addr_q;
endmodule

// File: rtl/ddr_seq_checker.sv
module ddr_seq_checker
    import ddr_seq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 7,
    parameter int T_RFC  = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [3:0]        cmd_n,
    input logic [1:0]        cmd_ba,
    input logic [ADDR_W-1:0] cmd_addr
);
    logic [NUM_BANKS-1:0] bus_open;
    logic [15:0] since_act [NUM_BANKS];
    logic [15:0] since_pre [NUM_BANKS];
    logic [15:0] since_ref;
    logic is_col;

    assign is_col = (cmd_n == CMD_RD) || (cmd_n == CMD_WR);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_open  <= '0;
            since_ref <= 16'hFFFF;
            for (int b = 0; b < NUM_BANKS; b++) begin
                since_act[b] <= 16'hFFFF;
                since_pre[b] <= 16'hFFFF;
            end
        end else begin
            if (since_ref != 16'hFFFF) since_ref <= since_ref + 1'b1;
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (since_act[b] != 16'hFFFF) since_act[b] <= since_act[b] + 1'b1;
                if (since_pre[b] != 16'hFFFF) since_pre[b] <= since_pre[b] + 1'b1;
            end
            case (cmd_n)
                CMD_ACT: begin
                    bus_open[cmd_ba]  <= 1'b1;
                    since_act[cmd_ba] <= 16'd1;
                end
                CMD_PRE: begin
                    bus_open[cmd_ba]  <= 1'b0;
                    since_pre[cmd_ba] <= 16'd1;
                end
                CMD_REF: since_ref <= 16'd1;
                default: if (is_col && cmd_addr[10]) bus_open[cmd_ba] <= 1'b0;
            endcase
        end
    end

    a_r2_legal_code: assert property (@(posedge clk) disable iff (rst)
        cmd_n inside {CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF});
    a_r3_act_to_closed: assert property (@(posedge clk) disable iff (rst)
        (cmd_n == CMD_ACT) |-> !bus_open[cmd_ba]);
    a_r4_col_to_open: assert property (@(posedge clk) disable iff (rst)
        is_col |-> bus_open[cmd_ba]);
    a_r5_rcd_met: assert property (@(posedge clk) disable iff (rst)
        is_col |-> since_act[cmd_ba] >= 16'(T_RCD));
    a_r7_ras_met: assert property (@(posedge clk) disable iff (rst)
        (cmd_n == CMD_PRE) |-> (since_act[cmd_ba] >= 16'(T_RAS)) && !cmd_addr[10]);
    a_r7_rp_met: assert property (@(posedge clk) disable iff (rst)
        (cmd_n == CMD_ACT) |-> since_pre[cmd_ba] >= 16'(T_RP));
    a_r11_ref_all_closed: assert property (@(posedge clk) disable iff (rst)
        (cmd_n == CMD_REF) |-> (bus_open == '0));
    a_r11_rfc_met: assert property (@(posedge clk) disable iff (rst)
        (cmd_n == CMD_ACT) |-> since_ref >= 16'(T_RFC));
    a_r13_ready_needs_valid: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> req_valid);
    a_r13_col_follows_ready: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> is_col);
endmodule

bind ddr_cmd_seq ddr_seq_checker #(
    .ADDR_W(ADDR_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RFC(T_RFC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd_n     (cmd_n),
    .cmd_ba    (cmd_ba),
    .cmd_addr  (cmd_addr)
);

// File: tb/sim_ddr_cmd_seq.sv
`timescale 1ns/1ps
module sim_ddr_cmd_seq;
    localparam int ROW_W = 13, COL_W = 10, ADDR_W = 13;
    localparam int T_RCD = 3, T_RP = 3, T_RAS = 7, T_RFC = 9, T_REFI = 2000;
    localparam int SLACK = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [1:0]        burst_sel = 2'b10;
    logic              req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
    logic [1:0]        req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic              req_ready;
    logic [3:0]        cmd_n;
    logic [1:0]        cmd_ba;
    logic [ADDR_W-1:0] cmd_addr;

    ddr_cmd_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .T_RCD(T_RCD),
        .T_RP(T_RP), .T_RAS(T_RAS), .T_RFC(T_RFC), .T_REFI(T_REFI)
    ) u0 (.*);

    typedef struct {
        bit wr; bit [1:0] bank; bit [12:0] row; bit [9:0] col; bit ap;
    } exp_t;
    exp_t sbq[$];

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    bit        mopen [4];
    bit [12:0] mrow  [4];
    int last_act [4], last_pre [4], ap_free [4];
    int last_ref = -1000, last_col = -1000, last_gap = 0, blc_last = 1;
    int n_ref = 0, n_act = 0, n_pre = 0, rst_rel = 0;
    bit rdy_prev = 0, streaming = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int blc_of(input logic [1:0] s);
        if (s == 2'b11) return 4;
        if (s == 2'b10) return 2;
        return 1;
    endfunction

    initial begin
        for (int b = 0; b < 4; b++) begin
            mopen[b] = 0; mrow[b] = '0;
            last_act[b] = -1000; last_pre[b] = -1000; ap_free[b] = 0;
        end
    end

    // Monitor: bus model, timing rules and scoreboard compare.
    always @(negedge clk) begin
        if (!rst) begin
            int t, b;
            t = cyc;
            b = int'(cmd_ba);
            case (cmd_n)
                4'b0011: begin
                    chk(!mopen[b], "R3", "ACTIVE to open bank", 1, 0);
                    chk(t - last_pre[b] >= T_RP, "R7", "PRE to ACT gap", t - last_pre[b], T_RP);
                    chk(t >= ap_free[b], "R10", "ACT after auto close", t, ap_free[b]);
                    chk(t - last_ref >= T_RFC, "R11", "REF to ACT gap", t - last_ref, T_RFC);
                    mopen[b] = 1; mrow[b] = cmd_addr[12:0]; last_act[b] = t; n_act++;
                end
                4'b0010: begin
                    chk(mopen[b], "R7", "PRE to closed bank", 0, 1);
                    chk(t - last_act[b] >= T_RAS, "R7", "ACT to PRE gap", t - last_act[b], T_RAS);
                    chk(cmd_addr[10] == 1'b0, "R7", "PRE addr bit 10", cmd_addr[10], 0);
                    mopen[b] = 0; last_pre[b] = t; n_pre++;
                end
                4'b0101, 4'b0100: begin
                    chk(rdy_prev, "R13", "column without accept", 0, 1);
                    if (sbq.size() == 0) begin
                        chk(0, "R13", "column with empty scoreboard", 1, 0);
                    end else begin
                        exp_t e;
                        e = sbq.pop_front();
                        chk((cmd_n == 4'b0100) == e.wr, "R4", "direction", cmd_n, e.wr ? 4 : 5);
                        chk(cmd_ba == e.bank, "R4", "bank", cmd_ba, e.bank);
                        chk(cmd_addr[9:0] == e.col, "R4", "column", cmd_addr[9:0], e.col);
                        chk(cmd_addr[10] == e.ap, "R4", "auto precharge bit", cmd_addr[10], e.ap);
                        chk(mopen[b] && mrow[b] == e.row, "R3", "open row at column", mrow[b], e.row);
                    end
                    chk(t - last_act[b] >= T_RCD, "R5", "ACT to column gap", t - last_act[b], T_RCD);
                    last_gap = t - last_col;
                    chk(last_gap >= blc_last, "R9", "column spacing", last_gap, blc_last);
                    last_col = t;
                    blc_last = blc_of(burst_sel);
                    if (cmd_addr[10]) begin
                        int a, c;
                        a = last_act[b] + T_RAS;
                        c = t + blc_last;
                        ap_free[b] = ((a > c) ? a : c) + T_RP;
                        mopen[b] = 0;
                    end
                end
                4'b0001: begin
                    chk(!(mopen[0] | mopen[1] | mopen[2] | mopen[3]), "R11",
                        "REF with open bank", 1, 0);
                    if (n_ref == 0)
                        chk(t - rst_rel >= T_REFI - SLACK && t - rst_rel <= T_REFI + SLACK,
                            "R11", "first REF time", t - rst_rel, T_REFI);
                    else if (streaming)
                        chk(t - last_ref >= T_REFI - SLACK && t - last_ref <= T_REFI + SLACK,
                            "R12", "REF interval under load", t - last_ref, T_REFI);
                    else
                        chk(t - last_ref >= T_REFI - SLACK && t - last_ref <= T_REFI + SLACK,
                            "R11", "REF interval", t - last_ref, T_REFI);
                    last_ref = t; n_ref++;
                end
                4'b0111: begin
                    if (rdy_prev) chk(0, "R13", "accept without column", 0, 1);
                end
                default: chk(0, "R2", "illegal command code", cmd_n, 7);
            endcase
            #1 rdy_prev = req_ready;
        end
    end

    task automatic send(input bit wr, input bit [1:0] bank, input bit [12:0] row,
                        input bit [9:0] col, input bit ap);
        exp_t e;
        e.wr = wr; e.bank = bank; e.row = row; e.col = col; e.ap = ap;
        sbq.push_back(e);
        req_write = wr; req_bank = bank; req_row = row; req_col = col;
        req_autopre = ap; req_valid = 1'b1;
        forever begin
            #1;
            if (req_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
        repeat (16) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", 100000, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int a0, p0;
        repeat (5) @(negedge clk);
        chk(cmd_n == 4'b0111, "R1", "bus in reset", cmd_n, 7);
        chk(req_ready == 1'b0, "R1", "ready in reset", req_ready, 0);
        rst = 1'b0;
        rst_rel = cyc;
        @(negedge clk);
        chk(cmd_n == 4'b0111, "R1", "bus after reset", cmd_n, 7);

        // R3: closed bank needs ACTIVE
        burst_sel = 2'b10;
        a0 = n_act;
        send(1, 0, 13'd5, 10'h012, 0);
        drain();
        chk(n_act == a0 + 1, "R3", "ACTIVE count first access", n_act - a0, 1);

        // R6: row hit
        a0 = n_act;
        send(0, 0, 13'd5, 10'h020, 0);
        drain();
        chk(n_act == a0, "R6", "ACTIVE count on hit", n_act - a0, 0);

        // R7: row miss
        a0 = n_act; p0 = n_pre;
        send(0, 0, 13'd9, 10'h033, 0);
        drain();
        chk(n_pre == p0 + 1, "R7", "PRE count on miss", n_pre - p0, 1);
        chk(n_act == a0 + 1, "R7", "ACTIVE count on miss", n_act - a0, 1);

        // R8: other bank, then back to bank 0 open row
        a0 = n_act; p0 = n_pre;
        send(1, 1, 13'd3, 10'h007, 0);
        send(0, 0, 13'd9, 10'h044, 0);
        drain();
        chk(n_act == a0 + 1, "R8", "ACTIVE count across banks", n_act - a0, 1);
        chk(n_pre == p0, "R8", "PRE count across banks", n_pre - p0, 0);

        // R9: burst spacing per selection
        burst_sel = 2'b11;
        send(0, 1, 13'd3, 10'h100, 0);
        send(0, 1, 13'd3, 10'h108, 0);
        drain();
        chk(last_gap == 4, "R9", "spacing burst 8", last_gap, 4);
        burst_sel = 2'b01;
        send(1, 1, 13'd3, 10'h110, 0);
        send(1, 1, 13'd3, 10'h112, 0);
        drain();
        chk(last_gap == 1, "R9", "spacing burst 2", last_gap, 1);
        burst_sel = 2'b00;
        send(0, 1, 13'd3, 10'h120, 0);
        send(0, 1, 13'd3, 10'h122, 0);
        drain();
        chk(last_gap == 1, "R9", "spacing select 00", last_gap, 1);
        burst_sel = 2'b10;
        send(0, 1, 13'd3, 10'h130, 0);
        send(0, 1, 13'd3, 10'h134, 0);
        drain();
        chk(last_gap == 2, "R9", "spacing burst 4", last_gap, 2);

        // R10: auto precharge closes the row without a bus PRECHARGE
        a0 = n_act; p0 = n_pre;
        send(1, 2, 13'd7, 10'h055, 1);
        send(0, 2, 13'd7, 10'h056, 0);
        drain();
        chk(n_act == a0 + 2, "R10", "ACTIVE count with auto close", n_act - a0, 2);
        chk(n_pre == p0, "R10", "PRE count with auto close", n_pre - p0, 0);

        // R11: periodic refresh with rows left open
        while (n_ref < 2) @(negedge clk);
        chk(n_ref == 2, "R11", "refresh count", n_ref, 2);

        // R12: continuous row misses across the third refresh point
        while (cyc < rst_rel + 3 * T_REFI - 150) @(negedge clk);
        streaming = 1;
        for (int i = 0; i < 40; i++)
            send(i[0], 2'd3, 13'(1 + (i % 2)), 10'(i), 0);
        drain();
        streaming = 0;
        chk(n_ref == 3, "R12", "refresh during stream", n_ref, 3);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule